// File: doc/BRIEF.md
# XT-style keyboard serial transmitter

This block is the keyboard end of a one-way, two-wire clock/data link to a PC/XT-style host. Scan bytes arrive over a valid/ready handshake. Each byte holds a 7-bit key code in bits 6:0 and a make/break flag in bit 7. The block sends each byte as a 9-bit frame. It owns the clock line as an open-drain output: it can only pull the line low or let go of it. It drives the data line directly. The host samples data on each falling edge of the clock.

The host can push back. While its receive buffer is full it holds the clock line low, and the transmitter waits before it starts a new frame. A clock-low that lasts longer than a threshold, while no frame is in flight, is a request to reset the keyboard. After reset, and again after each such request, the block waits a start-up delay and then sends the self-test-complete byte 0xAA on its own.

The controller is a five-state machine:

- **ST_BOOT**: counts the start-up delay, then loads 0xAA (BOOT→HOLDOFF).
- **ST_IDLE**: the clock is released, data is low and ready is high. An accepted byte moves to HOLDOFF.
- **ST_HOLDOFF**: waits until the synchronised clock line reads high (HOLDOFF→HI).
- **ST_HI**: the clock is released and the current bit is on data (HI→LO after one half period).
- **ST_LO**: the clock is pulled low with the same bit on data. After one half period it goes LO→HI for the next bit, or LO→IDLE after the ninth bit.

A host reset pulse moves any state to ST_BOOT.

Top module: `xt_kbd_tx`

## Requirements
- R1: While idle, `byte_ready` is 1, `kclk_pull_low` is 0 and `kdata_out` is 0. `byte_ready` is 1 in no other state, and it falls in the cycle after a byte is accepted.
- R2: A frame starts only after the clock line, seen through a two-flop synchroniser, reads high. While the host holds the line low, the block never pulls the clock low.
- R3: Frame bit 0 (the start bit) is 1.
- R4: Frame bits 1 to 7 carry byte bits 0 to 6, least significant bit first.
- R5: Frame bit 8 is byte bit 7, the make/break flag (1 = release, 0 = press).
- R6: Each bit takes HALF_CYC cycles with the clock released, then HALF_CYC cycles with the clock pulled low. `kdata_out` is set at the start of the released phase and stays constant through the falling edge and the whole low phase.
- R7: After reset the block waits BOOT_CYC cycles and then sends the byte 0xAA without any request.
- R8: If the synchronised clock line reads low for HOLD_RST_CYC consecutive cycles while no frame is in flight, `host_reset_req` pulses for exactly one cycle. The block then goes back to ST_BOOT, drops any pending byte and sends 0xAA again.
- R9: After the low phase of the ninth bit, the clock is released, data returns to 0 and `byte_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A scan byte is offered |
| byte_data | input | 8 | Scan byte: bits 6:0 key code, bit 7 make/break |
| byte_ready | output | 1 | The block accepts a byte this cycle |
| kclk_in | input | 1 | Level read back from the shared clock line |
| kclk_pull_low | output | 1 | 1 = pull the clock line low; 0 = release it |
| kdata_out | output | 1 | Level driven on the data line |
| host_reset_req | output | 1 | One-cycle pulse when a host reset is detected |

## Verification
The outputs decode registered state, so each one changes in the cycle right after the edge that moves the machine. A sampled clock level takes two extra cycles to reach the holdoff check and the hold counter. The reset pulse therefore comes one cycle after the HOLD_RST_CYC-th synchronised low cycle. The bench's behavioural model applies the same per-edge latencies and is compared with the outputs at every falling system-clock edge. Its host-side receiver checks each frame's bits at the line's falling edges, in the order the frames were expected.

// File: rtl/xtk_pkg.sv
package xtk_pkg;

    localparam int FRAME_BITS = 9;
    localparam logic [7:0] SELFTEST_OK = 8'hAA;

    typedef enum logic [2:0] {
        ST_BOOT    = 3'd0,
        ST_IDLE    = 3'd1,
        ST_HOLDOFF = 3'd2,
        ST_HI      = 3'd3,
        ST_LO      = 3'd4
    } xtk_state_e;

    // Frame layout, bit 0 first on the wire: start (1), code[6:0], make/break
    function automatic logic [FRAME_BITS-1:0] xtk_frame(input logic [7:0] scan);
        return {scan[7], scan[6:0], 1'b1};
    endfunction

endpackage

// File: rtl/xtk_sync.sv
module xtk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/xtk_phase_timer.sv
module xtk_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/xtk_hold_detect.sv
module xtk_hold_detect #(
    parameter int LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_low,
    input  logic tx_active,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] low_cnt;
    logic          counting;

    assign counting = line_low && !tx_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            hit     <= 1'b0;
        end else begin
            hit <= counting && (low_cnt == CW'(LIMIT - 1));
            if (!counting) begin
                low_cnt <= '0;
            end else if (low_cnt != CW'(LIMIT)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    AST_RESET_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R8

    AST_RESET_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(line_low)); // R8

endmodule

// File: rtl/xt_kbd_tx.sv
module xt_kbd_tx
    import xtk_pkg::*;
#(
    parameter int HALF_CYC     = 6250,
    parameter int BOOT_CYC     = 62500,
    parameter int HOLD_RST_CYC = 2500000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       byte_ready,
    input  logic       kclk_in,
    output logic       kclk_pull_low,
    output logic       kdata_out,
    output logic       host_reset_req
);
    localparam int TMR_MAX = (HALF_CYC > BOOT_CYC) ? HALF_CYC : BOOT_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX) + 1;
    localparam int IDX_W   = $clog2(FRAME_BITS);

    xtk_state_e             state_q, state_d;
    logic [FRAME_BITS-1:0]  frame_q, frame_d;
    logic [IDX_W-1:0]       idx_q, idx_d;
    logic [TMR_W-1:0]       tmr_cnt;
    logic                   tmr_restart;
    logic                   clk_s;
    logic                   rst_hit;
    logic                   tx_active;
    logic                   phase_done;
    logic                   boot_done;
    logic                   last_bit;

    xtk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (kclk_in),
        .q     (clk_s)
    );

    xtk_phase_timer #(.CNT_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .count   (tmr_cnt)
    );

    xtk_hold_detect #(.LIMIT(HOLD_RST_CYC)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_low  (!clk_s),
        .tx_active (tx_active),
        .hit       (rst_hit)
    );

    assign tx_active   = (state_q == ST_HI) || (state_q == ST_LO);
    assign phase_done  = (tmr_cnt == TMR_W'(HALF_CYC - 1));
    assign boot_done   = (tmr_cnt == TMR_W'(BOOT_CYC - 1));
    assign last_bit    = (idx_q == IDX_W'(FRAME_BITS - 1));
    assign tmr_restart = (state_d != state_q) || rst_hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        frame_d = frame_q;
        idx_d   = idx_q;
        if (rst_hit) begin
            state_d = ST_BOOT;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    if (boot_done) begin
                        frame_d = xtk_frame(SELFTEST_OK);
                        state_d = ST_HOLDOFF;
                    end
                end
                ST_IDLE: begin
                    if (byte_valid) begin
                        frame_d = xtk_frame(byte_data);
                        state_d = ST_HOLDOFF;
                    end
                end
                ST_HOLDOFF: begin
                    if (clk_s) begin
                        idx_d   = '0;
                        state_d = ST_HI;
                    end
                end
                ST_HI: begin
                    if (phase_done) begin
                        state_d = ST_LO;
                    end
                end
                ST_LO: begin
                    if (phase_done) begin
                        if (last_bit) begin
                            state_d = ST_IDLE;
                        end else begin
                            idx_d   = idx_q + 1'b1;
                            state_d = ST_HI;
                        end
                    end
                end
                default: begin
                    state_d = ST_BOOT;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            frame_q <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            frame_q <= frame_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        byte_ready     = 1'b0;
        kclk_pull_low  = 1'b0;
        kdata_out      = 1'b0;
        host_reset_req = rst_hit;
        unique case (state_q)
            ST_IDLE: byte_ready = 1'b1;
            ST_HI:   kdata_out  = frame_q[idx_q];
            ST_LO: begin
                kclk_pull_low = 1'b1;
                kdata_out     = frame_q[idx_q];
            end
            default: ;
        endcase
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (!kclk_pull_low && !kdata_out)); // R1

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready && !host_reset_req) |=> !byte_ready); // R1

    AST_HOLDOFF_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDOFF && !clk_s && !rst_hit) |=> !kclk_pull_low); // R2

    AST_START_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_HOLDOFF && state_q == ST_HI) |-> kdata_out); // R3

    AST_DATA_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kclk_pull_low) |-> $stable(kdata_out)); // R6

    AST_DATA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (kclk_pull_low && $past(kclk_pull_low)) |-> $stable(kdata_out)); // R6

    AST_HOST_RESET_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        host_reset_req |=> (state_q == ST_BOOT && !byte_ready)); // R8

    AST_END_OF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(kclk_pull_low) && $past(last_bit) && !$past(rst_hit)) |-> (byte_ready && !kdata_out)); // R9

endmodule

// File: tb/xt_kbd_tx_bench.sv
module xt_kbd_tx_bench;
    localparam int HALF = 4;
    localparam int BOOT = 10;
    localparam int TH   = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       host_hold = 1'b0;
    logic       byte_ready, kclk_pull_low, kdata_out, host_reset_req;
    logic       clk_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign clk_line = !(kclk_pull_low || host_hold);

    xt_kbd_tx #(.HALF_CYC(HALF), .BOOT_CYC(BOOT), .HOLD_RST_CYC(TH)) u_xt_kbd_tx (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .kclk_in(clk_line), .kclk_pull_low(kclk_pull_low),
        .kdata_out(kdata_out), .host_reset_req(host_reset_req)
    );

    // Behavioural reference: mode 0 boot, 1 idle, 2 holdoff, 3 released, 4 pulled low
    int         m_mode, m_cnt, m_bit, m_low;
    bit         m_hit;
    bit [8:0]   m_frame;
    bit [1:0]   m_sync;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_bit = 0; m_low = 0; m_hit = 0;
            m_frame = '0; m_sync = 2'b11;
        end else begin
            bit ks, act, nh;
            int nl;
            ks  = m_sync[1];
            act = (m_mode == 3) || (m_mode == 4);
            nh  = !ks && !act && (m_low == TH - 1);
            nl  = (!ks && !act) ? ((m_low == TH) ? TH : m_low + 1) : 0;
            if (m_hit) begin
                m_mode = 0; m_cnt = 0; m_bit = 0;
            end else begin
                case (m_mode)
                    0: if (m_cnt == BOOT - 1) begin
                           m_frame = {8'hAA, 1'b1}; m_mode = 2; m_cnt = 0;
                       end else m_cnt++;
                    1: if (byte_valid) begin
                           m_frame = {byte_data, 1'b1}; m_mode = 2; m_cnt = 0;
                       end
                    2: if (ks) begin m_mode = 3; m_bit = 0; m_cnt = 0; end
                    3: if (m_cnt == HALF - 1) begin m_mode = 4; m_cnt = 0; end
                       else m_cnt++;
                    4: if (m_cnt == HALF - 1) begin
                           m_cnt = 0;
                           if (m_bit == 8) m_mode = 1;
                           else begin m_bit++; m_mode = 3; end
                       end else m_cnt++;
                    default: m_mode = 0;
                endcase
            end
            m_hit  = nh;
            m_low  = nl;
            m_sync = {m_sync[0], clk_line};
        end
    end

    // Host-side receiver
    logic [7:0] expq[$];
    bit         prev_line = 1'b1;
    int         rx_n = 0;
    bit [8:0]   rx_bits;

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_rdy, e_low, e_dat;
            e_rdy = (m_mode == 1);
            e_low = (m_mode == 4);
            e_dat = (m_mode == 3 || m_mode == 4) ? m_frame[m_bit] : 1'b0;
            chk(byte_ready == e_rdy, "R1 ready", int'(byte_ready), int'(e_rdy));
            chk(kclk_pull_low == e_low, "R6 clock", int'(kclk_pull_low), int'(e_low));
            chk(kdata_out == e_dat, "R4 data", int'(kdata_out), int'(e_dat));
            chk(host_reset_req == m_hit, "R8 reset pulse", int'(host_reset_req), int'(m_hit));
            if (prev_line && !clk_line && !host_hold) begin
                rx_bits[rx_n] = kdata_out;
                rx_n++;
                if (rx_n == 9) begin
                    logic [7:0] ex;
                    rx_n = 0;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R7 unexpected frame", int'(rx_bits), 0);
                    end else begin
                        ex = expq.pop_front();
                        chk(rx_bits[0] == 1'b1, "R3 start bit", int'(rx_bits[0]), 1);
                        chk(rx_bits[7:1] == ex[6:0], "R4 key code", int'(rx_bits[7:1]), int'(ex[6:0]));
                        chk(rx_bits[8] == ex[7], "R5 make/break", int'(rx_bits[8]), int'(ex[7]));
                    end
                end
            end
        end
        prev_line = clk_line;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!byte_ready && guard < 5000) begin
            step(1);
            guard++;
        end
    endtask

    task automatic send(input logic [7:0] b);
        wait_ready();
        byte_valid = 1'b1;
        byte_data  = b;
        expq.push_back(b);
        step(1);
        byte_valid = 1'b0;
        chk(!byte_ready, "R1 ready falls after accept", int'(byte_ready), 0);
    endtask

    initial begin
        int pulls, pulses;
        step(4);
        rst_n = 1'b1;
        #2;
        chk(!byte_ready && !kclk_pull_low && !kdata_out, "R7 reset state",
            int'({byte_ready, kclk_pull_low, kdata_out}), 0);
        expq.push_back(8'hAA);           // R7 self-test byte after start-up delay
        wait_ready();
        chk(expq.size() == 0, "R7 self-test frame seen", expq.size(), 0);
        chk(!kclk_pull_low && !kdata_out, "R9 lines after frame",
            int'({kclk_pull_low, kdata_out}), 0);

        send(8'h1C);   // R5 press
        send(8'h9C);   // R5 release
        send(8'h7F);
        send(8'h80);
        send(8'h00);
        send(8'hFF);
        send(8'h55);
        wait_ready();
        chk(expq.size() == 0, "R4 all frames received", expq.size(), 0);

        // R2: host holds clock low, frame must wait
        host_hold = 1'b1;
        step(3);
        send(8'h2A);
        pulls = 0;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (kclk_pull_low) pulls++;
        end
        chk(pulls == 0, "R2 no clock pulse while host holds", pulls, 0);
        chk(expq.size() == 1, "R2 frame deferred", expq.size(), 1);
        host_hold = 1'b0;
        wait_ready();
        chk(expq.size() == 0, "R2 deferred frame sent", expq.size(), 0);

        // R8: long host clock-low resets the keyboard
        host_hold = 1'b1;
        pulses = 0;
        for (int i = 0; i < TH + 20; i++) begin
            step(1);
            if (host_reset_req) pulses++;
        end
        chk(pulses == 1, "R8 single reset pulse", pulses, 1);
        chk(!byte_ready, "R8 not ready after host reset", int'(byte_ready), 0);
        expq.push_back(8'hAA);
        host_hold = 1'b0;
        wait_ready();
        chk(expq.size() == 0, "R8 self-test resent", expq.size(), 0);

        // R2: short hold below threshold gives no reset
        host_hold = 1'b1;
        pulses = 0;
        for (int i = 0; i < TH / 2; i++) begin
            step(1);
            if (host_reset_req) pulses++;
        end
        host_hold = 1'b0;
        chk(pulses == 0, "R8 short hold no reset", pulses, 0);
        send(8'h01);
        wait_ready();
        step(20);
        chk(expq.size() == 0, "R9 final frame done", expq.size(), 0);
        chk(byte_ready && !kclk_pull_low && !kdata_out, "R1 idle lines",
            int'({byte_ready, kclk_pull_low, kdata_out}), 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule